// File: doc/BRIEF.md
# Page-List Scatter-Gather DMA Engine

This block is a bus-master DMA engine. It moves a programmed number of bytes between a byte-wide device stream and host memory, in either direction. Host memory is given as a table of 32-bit page-frame addresses held in memory. Each table entry maps one 4096-byte page of the transfer. Only the first page may begin part-way in, at a byte offset held in its own register. Every later page begins at byte 0. A mode bit turns off the table walk, and the engine then treats the base register as one contiguous, page-aligned region.

Software programs four registers through a simple write port: the control word, the byte count, the first-page offset and the table (or region) base. It starts a transfer by writing the control word twice, first with the IDLE command and then with START, with the same direction and mode bits both times. The engine fetches table entries through a read port with a same-cycle grant. It moves data as 32-bit little-endian words with byte enables through a memory port that has a same-cycle ready. Four sticky status bits report the outcome: done, bus error, aborted and flush complete. The stored command field is returned to software so that it can poll for activity.

Top module: `pgl_dma`

## Requirements
- R1: After reset the status bits are 0, the command field reads IDLE (0), and no request is raised on the table, memory or device ports.
- R2: In table mode the engine reads entries at base, base+4, base+8 and so on. It uses bits [31:12] of an entry as the page frame and ignores bits [11:0]. Each entry covers 4096 bytes. The next entry is read only after the last byte of the current page has been moved, and never after the final byte of the transfer.
- R3: Byte i of the transfer goes to offset (first_offset + i) of the page sequence. The first-page offset is register select 2, bits [11:0]. Every later page starts at offset 0.
- R4: Device-to-memory: byte k of a 32-bit word sits in lane k (bits 8k+7..8k), at address bits [1:0] = k. A word is written with enables only for the lanes it received. It is written when lane 3 is filled or when the count is exhausted, so every touched word is written exactly once.
- R5: Memory-to-device: each word is read with all four enables set. The device receives the bytes from the current lane upward, in transfer order.
- R6: The 24-bit count (register select 1) drops by one per byte moved. DONE (status bit 0) is set after the last byte has been moved, including its memory write in the device-to-memory direction.
- R7: START with a count of 0 performs no table or memory access and sets DONE on the next clock.
- R8: ABORT (command 2) removes every memory and table request from the next clock on, and sets ABT (status bit 2).
- R9: BLAST (command 1) during a device-to-memory transfer first writes any partly filled word with its own enables, then sets BCMP (status bit 3). If no partial word is held, BCMP is set and nothing is written.
- R10: A bus error on an accepted memory access sets ERR (status bit 1), stops the transfer and leaves DONE clear.
- R11: The control word is register select 0, with the command in bits [1:0] (IDLE=0, BLAST=1, ABORT=2, START=3), the direction in bit 2 (1 means device to memory) and table mode in bit 3. The written command field is output as-is, and busy is high whenever it is not IDLE. Status bits stay set until the next START.
- R12: With table mode clear, the base register (select 3) is a page-aligned region start. The page frame increments after each page end, and no table read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 count, 2 offset, 3 base |
| reg_wdata | input | 32 | Register write data |
| cmd_o | output | 2 | Stored command field |
| busy_o | output | 1 | Command field is not IDLE |
| status_o | output | 4 | {BCMP, ABT, ERR, DONE} sticky status |
| lst_req | output | 1 | Table entry read request |
| lst_addr | output | 32 | Table entry address |
| lst_gnt | input | 1 | Table read granted, data valid this cycle |
| lst_rdata | input | 32 | Table entry data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_err | input | 1 | Bus error on the accepted access |
| dev_rd_valid | input | 1 | Device byte available |
| dev_rd_data | input | 8 | Device byte |
| dev_rd_ready | output | 1 | Engine takes the device byte |
| dev_wr_valid | output | 1 | Engine offers a byte to the device |
| dev_wr_data | output | 8 | Byte to the device |
| dev_wr_ready | input | 1 | Device takes the byte |

## Verification
The assertions assume that the table and memory ports answer in the cycle the request is accepted, that the table base is word aligned, and that START is written only while the engine is idle. They also assume that ABORT or BLAST arrives as a single control write rather than alongside other commands. The stimulus respects these conditions. Its memory model always grants, returns data combinationally and raises an error only while a fault flag is set. Each control write is one strobe per cycle, and every START follows a finished, aborted or flushed run.

// File: rtl/pgl_dma_pkg.sv
`timescale 1ns/1ps
// Shared types and constants of the page-list DMA engine.
// Assumes a 32-bit register write port and four sticky status bits.
package pgl_dma_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_BLAST = 2'd1,
        CMD_ABORT = 2'd2,
        CMD_START = 2'd3
    } dma_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_RD, S_EMIT, S_GATHER, S_WR
    } dma_state_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_OFS  = 2'd2;
    localparam logic [1:0] SEL_BASE = 2'd3;

    localparam int DIR_BIT  = 2;
    localparam int LIST_BIT = 3;

    localparam int ST_DONE = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_ABT  = 2;
    localparam int ST_BCMP = 3;
endpackage

// File: rtl/pgl_dma_regs.sv
`timescale 1ns/1ps
// Host-programmed registers of the DMA engine, plus single-cycle command
// pulses decoded from a control write. Assumes at most one write per cycle.
module pgl_dma_regs import pgl_dma_pkg::*; #(
    parameter int AW    = 32,
    parameter int CNT_W = 24,
    parameter int PG_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    output dma_cmd_e         cmd_q,
    output logic             dir_q,
    output logic             list_q,
    output logic [CNT_W-1:0] cnt_init,
    output logic [PG_W-1:0]  ofs_init,
    output logic [AW-1:0]    base_q,
    output logic             start_p,
    output logic             abort_p,
    output logic             blast_p,
    output logic             wr_dir,
    output logic             wr_list
);
    logic     ctrl_wr;
    dma_cmd_e wcmd;

    // Decode a control write into command pulses.
    always_comb begin
        ctrl_wr = reg_we && (reg_sel == SEL_CTRL);
        wcmd    = dma_cmd_e'(reg_wdata[1:0]);
        start_p = ctrl_wr && (wcmd == CMD_START);
        abort_p = ctrl_wr && (wcmd == CMD_ABORT);
        blast_p = ctrl_wr && (wcmd == CMD_BLAST);
        wr_dir  = reg_wdata[DIR_BIT];
        wr_list = reg_wdata[LIST_BIT];
    end

    // Hold the written register values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= CMD_IDLE;
            dir_q    <= 1'b0;
            list_q   <= 1'b0;
            cnt_init <= '0;
            ofs_init <= '0;
            base_q   <= '0;
        end else if (reg_we) begin
            case (reg_sel)
                SEL_CTRL: begin
                    cmd_q  <= wcmd;
                    dir_q  <= wr_dir;
                    list_q <= wr_list;
                end
                SEL_CNT:  cnt_init <= reg_wdata[CNT_W-1:0];
                SEL_OFS:  ofs_init <= reg_wdata[PG_W-1:0];
                default:  base_q   <= reg_wdata[AW-1:0];
            endcase
        end
    end
endmodule

// File: rtl/pgl_dma_lanes.sv
`timescale 1ns/1ps
// Word buffer with per-lane byte enables. It packs device bytes into a
// little-endian word and selects the outgoing byte of a word read from
// memory. Assumes load and put never occur in the same cycle.
module pgl_dma_lanes #(
    parameter int LANES = 4,
    localparam int DW = LANES * 8,
    localparam int LW = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [DW-1:0]    ld_word,
    input  logic             put,
    input  logic [LW-1:0]    lane,
    input  logic [7:0]       put_byte,
    output logic [DW-1:0]    word,
    output logic [LANES-1:0] be,
    output logic [7:0]       sel_byte
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One byte lane: take a read word or a device byte, track its enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word[g*8 +: 8] <= '0;
                be[g]          <= 1'b0;
            end else begin
                if (load)
                    word[g*8 +: 8] <= ld_word[g*8 +: 8];
                else if (put && lane == LW'(g))
                    word[g*8 +: 8] <= put_byte;
                if (clr)
                    be[g] <= 1'b0;
                else if (put && lane == LW'(g))
                    be[g] <= 1'b1;
            end
        end
    end

    // Select the byte for the current lane.
    always_comb sel_byte = word[lane*8 +: 8];
endmodule

// File: rtl/pgl_dma_ctrl.sv
`timescale 1ns/1ps
// Transfer sequencer: walks the page table, tracks page offset and byte
// count, and drives the table, memory and device handshakes. Assumes the
// table and memory ports return data or error in the accepting cycle.
module pgl_dma_ctrl import pgl_dma_pkg::*; #(
    parameter int AW    = 32,
    parameter int CNT_W = 24,
    parameter int PG_W  = 12,
    parameter int LANES = 4,
    localparam int LW   = $clog2(LANES),
    localparam int PN_W = AW - PG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_in,
    input  logic             abort_in,
    input  logic             blast_in,
    input  logic             start_dir,
    input  logic             start_list,
    input  logic             dir_q,
    input  logic             list_q,
    input  logic [CNT_W-1:0] cnt_init,
    input  logic [PG_W-1:0]  ofs_init,
    input  logic [AW-1:0]    base_q,
    output logic             lst_req,
    output logic [AW-1:0]    lst_addr,
    input  logic             lst_gnt,
    input  logic [AW-1:0]    lst_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_ready,
    input  logic             mem_err,
    input  logic             dev_rd_valid,
    output logic             dev_rd_ready,
    output logic             dev_wr_valid,
    input  logic             dev_wr_ready,
    input  logic             any_lane,
    output logic [LW-1:0]    lane,
    output logic             pk_load,
    output logic             pk_put,
    output logic             pk_clr,
    output logic [3:0]       status
);
    dma_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [PG_W-1:0]  ofs;
    logic [PN_W-1:0]  page;
    logic [AW-1:0]    lptr;
    logic             flush;
    logic             halt_in, mem_acc, byte_in, byte_out, pg_end, wd_end;

    // Port handshakes; a halting command withholds new traffic at once.
    always_comb begin
        halt_in      = abort_in || blast_in;
        lst_req      = (state == S_FETCH) && !halt_in;
        lst_addr     = lptr;
        mem_req      = ((state == S_RD) && !halt_in) || ((state == S_WR) && !abort_in);
        mem_we       = (state == S_WR);
        mem_addr     = {page, ofs[PG_W-1:LW], LW'(0)};
        dev_rd_ready = (state == S_GATHER) && !halt_in;
        dev_wr_valid = (state == S_EMIT) && !halt_in;
        mem_acc      = mem_req && mem_ready;
        byte_in      = dev_rd_valid && dev_rd_ready;
        byte_out     = dev_wr_valid && dev_wr_ready;
        pg_end       = (ofs == {PG_W{1'b1}});
        wd_end       = (ofs[LW-1:0] == LW'(LANES - 1));
        lane         = ofs[LW-1:0];
        pk_load      = (state == S_RD) && mem_acc;
        pk_put       = byte_in;
        pk_clr       = ((state == S_WR) && mem_acc) || ((state == S_IDLE) && start_in);
    end

    // Sequencer: state, counters, page pointer and sticky status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            ofs    <= '0;
            page   <= '0;
            lptr   <= '0;
            flush  <= 1'b0;
            status <= '0;
        end else if (abort_in) begin
            state          <= S_IDLE;
            flush          <= 1'b0;
            status[ST_ABT] <= 1'b1;
        end else begin
            case (state)
                S_IDLE: begin
                    if (blast_in) status[ST_BCMP] <= 1'b1;
                    else if (start_in) begin
                        cnt   <= cnt_init;
                        ofs   <= ofs_init;
                        page  <= base_q[AW-1:PG_W];
                        lptr  <= base_q;
                        flush <= 1'b0;
                        status <= (cnt_init == '0) ? 4'b0001 : 4'b0000;
                        if (cnt_init != '0)
                            state <= start_list ? S_FETCH : (start_dir ? S_GATHER : S_RD);
                    end
                end
                S_FETCH: begin
                    if (blast_in) begin
                        status[ST_BCMP] <= 1'b1;
                        state           <= S_IDLE;
                    end else if (lst_gnt) begin
                        page  <= lst_rdata[AW-1:PG_W];
                        lptr  <= lptr + AW'(4);
                        state <= dir_q ? S_GATHER : S_RD;
                    end
                end
                S_RD: begin
                    if (blast_in) begin
                        status[ST_BCMP] <= 1'b1;
                        state           <= S_IDLE;
                    end else if (mem_acc) begin
                        if (mem_err) begin
                            status[ST_ERR] <= 1'b1;
                            state          <= S_IDLE;
                        end else state <= S_EMIT;
                    end
                end
                S_EMIT: begin
                    if (blast_in) begin
                        status[ST_BCMP] <= 1'b1;
                        state           <= S_IDLE;
                    end else if (byte_out) begin
                        cnt <= cnt - 1'b1;
                        if (cnt == CNT_W'(1)) begin
                            status[ST_DONE] <= 1'b1;
                            state           <= S_IDLE;
                        end else if (pg_end) begin
                            ofs <= '0;
                            if (list_q) state <= S_FETCH;
                            else begin
                                page  <= page + 1'b1;
                                state <= S_RD;
                            end
                        end else begin
                            ofs <= ofs + 1'b1;
                            if (wd_end) state <= S_RD;
                        end
                    end
                end
                S_GATHER: begin
                    if (blast_in) begin
                        if (any_lane) begin
                            flush <= 1'b1;
                            state <= S_WR;
                        end else begin
                            status[ST_BCMP] <= 1'b1;
                            state           <= S_IDLE;
                        end
                    end else if (byte_in) begin
                        cnt <= cnt - 1'b1;
                        if (cnt == CNT_W'(1) || wd_end) state <= S_WR;
                        else ofs <= ofs + 1'b1;
                    end
                end
                S_WR: begin
                    if (blast_in) flush <= 1'b1;
                    if (mem_acc) begin
                        if (mem_err) begin
                            status[ST_ERR] <= 1'b1;
                            state          <= S_IDLE;
                        end else if (flush || blast_in) begin
                            flush           <= 1'b0;
                            status[ST_BCMP] <= 1'b1;
                            state           <= S_IDLE;
                        end else if (cnt == '0) begin
                            status[ST_DONE] <= 1'b1;
                            state           <= S_IDLE;
                        end else if (pg_end) begin
                            ofs <= '0;
                            if (list_q) state <= S_FETCH;
                            else begin
                                page  <= page + 1'b1;
                                state <= S_GATHER;
                            end
                        end else begin
                            ofs   <= ofs + 1'b1;
                            state <= S_GATHER;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R8: after ABORT no request is left and ABT is set.
    a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        abort_in |=> (!mem_req && !lst_req && status[ST_ABT]));

    // R7: zero-count START finishes at once with DONE only.
    a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start_in && state == S_IDLE && cnt_init == '0) |=> (state == S_IDLE && status == 4'b0001));

    // R11: status bits stay set until a START.
    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_DONE] && !start_in) |=> status[ST_DONE]);

    // R6: any byte-moving state still has bytes left to move.
    a_r6_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {S_RD, S_EMIT, S_GATHER}) |-> (cnt != '0));

    // R2: only one port is active in any cycle.
    a_r2_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, lst_req, dev_rd_ready, dev_wr_valid}));
endmodule

// File: rtl/pgl_dma.sv
`timescale 1ns/1ps
// Page-list scatter-gather DMA engine, top level. It joins the register
// file, the sequencer and the lane buffer. Assumes the table base is word
// aligned and that START is written only while the engine is idle.
module pgl_dma import pgl_dma_pkg::*; #(
    parameter int AW    = 32,
    parameter int CNT_W = 24,
    parameter int PG_W  = 12,
    parameter int LANES = 4,
    localparam int DW   = LANES * 8,
    localparam int LW   = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [1:0]       cmd_o,
    output logic             busy_o,
    output logic [3:0]       status_o,
    output logic             lst_req,
    output logic [AW-1:0]    lst_addr,
    input  logic             lst_gnt,
    input  logic [AW-1:0]    lst_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [LANES-1:0] mem_be,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ready,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_err,
    input  logic             dev_rd_valid,
    input  logic [7:0]       dev_rd_data,
    output logic             dev_rd_ready,
    output logic             dev_wr_valid,
    output logic [7:0]       dev_wr_data,
    input  logic             dev_wr_ready
);
    dma_cmd_e         cmd_q;
    logic             dir_q, list_q, start_p, abort_p, blast_p, wr_dir, wr_list;
    logic [CNT_W-1:0] cnt_init;
    logic [PG_W-1:0]  ofs_init;
    logic [AW-1:0]    base_q;
    logic [LW-1:0]    lane;
    logic             pk_load, pk_put, pk_clr;
    logic [LANES-1:0] be;

    pgl_dma_regs #(.AW(AW), .CNT_W(CNT_W), .PG_W(PG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_q(cmd_q), .dir_q(dir_q), .list_q(list_q),
        .cnt_init(cnt_init), .ofs_init(ofs_init), .base_q(base_q),
        .start_p(start_p), .abort_p(abort_p), .blast_p(blast_p),
        .wr_dir(wr_dir), .wr_list(wr_list)
    );

    pgl_dma_ctrl #(.AW(AW), .CNT_W(CNT_W), .PG_W(PG_W), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_in(start_p), .abort_in(abort_p),
        .blast_in(blast_p), .start_dir(wr_dir), .start_list(wr_list),
        .dir_q(dir_q), .list_q(list_q), .cnt_init(cnt_init),
        .ofs_init(ofs_init), .base_q(base_q), .lst_req(lst_req),
        .lst_addr(lst_addr), .lst_gnt(lst_gnt), .lst_rdata(lst_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_err(mem_err), .dev_rd_valid(dev_rd_valid),
        .dev_rd_ready(dev_rd_ready), .dev_wr_valid(dev_wr_valid),
        .dev_wr_ready(dev_wr_ready), .any_lane(|be), .lane(lane),
        .pk_load(pk_load), .pk_put(pk_put), .pk_clr(pk_clr), .status(status_o)
    );

    pgl_dma_lanes #(.LANES(LANES)) u_lanes (
        .clk(clk), .rst_n(rst_n), .clr(pk_clr), .load(pk_load),
        .ld_word(mem_rdata), .put(pk_put), .lane(lane), .put_byte(dev_rd_data),
        .word(mem_wdata), .be(be), .sel_byte(dev_wr_data)
    );

    // Command readback and memory lane enables.
    always_comb begin
        cmd_o  = cmd_q;
        busy_o = (cmd_q != CMD_IDLE);
        mem_be = mem_we ? be : '1;
    end

    // R4: a memory write always carries at least one enabled lane.
    a_r4_write_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be != '0));
endmodule

// File: tb/test_pgl_dma.sv
`timescale 1ns/1ps
module test_pgl_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  cmd_o;
    logic        busy_o;
    logic [3:0]  status_o;
    logic        lst_req, mem_req, mem_we, dev_rd_ready, dev_wr_valid;
    logic [31:0] lst_addr, lst_rdata, mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic [7:0]  dev_rd_data, dev_wr_data;
    logic        dev_rd_valid, mem_err;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] mem_b [0:16383];
    logic [7:0] snk_b [0:8191];
    int  src_idx, src_lim, snk_idx, wr_cnt, rd_cnt, lst_cnt, vec_id;
    logic fill_req = 1'b0;
    logic err_inj = 1'b0;

    always #2.5 clk = ~clk;

    pgl_dma i_pgl_dma (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_o(cmd_o), .busy_o(busy_o),
        .status_o(status_o), .lst_req(lst_req), .lst_addr(lst_addr),
        .lst_gnt(1'b1), .lst_rdata(lst_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ready(1'b1), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .dev_rd_valid(dev_rd_valid),
        .dev_rd_data(dev_rd_data), .dev_rd_ready(dev_rd_ready),
        .dev_wr_valid(dev_wr_valid), .dev_wr_data(dev_wr_data),
        .dev_wr_ready(1'b1)
    );

    function automatic logic [7:0] bg(int a);
        return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] src(int k, int v);
        return 8'(k * 3 + v * 29 + 7);
    endfunction

    // Page frames placed in the table, in table order.
    function automatic int pg_frame(int i);
        return (i == 0) ? 32'h2000 : (i == 1) ? 32'h1000 : 32'h3000;
    endfunction

    function automatic int pos2addr(bit lst, int pos);
        if (lst) return pg_frame(pos >> 12) + (pos & 32'hFFF);
        return 32'h1000 + pos;
    endfunction

    logic [13:0] ma, la;
    assign ma        = {mem_addr[13:2], 2'b00};
    assign la        = {lst_addr[13:2], 2'b00};
    assign mem_rdata = {mem_b[ma+3], mem_b[ma+2], mem_b[ma+1], mem_b[ma]};
    assign lst_rdata = {mem_b[la+3], mem_b[la+2], mem_b[la+1], mem_b[la]};
    assign mem_err   = err_inj && mem_req;
    assign dev_rd_valid = (src_idx < src_lim);
    assign dev_rd_data  = src(src_idx, vec_id);

    // Memory, table and device models; the only writer of their state.
    always @(posedge clk) begin
        if (fill_req) begin
            for (int a = 0; a < 16384; a++) mem_b[a] <= bg(a);
            {mem_b[3], mem_b[2], mem_b[1], mem_b[0]}    <= 32'h0000_2005;
            {mem_b[7], mem_b[6], mem_b[5], mem_b[4]}    <= 32'h0000_1000;
            {mem_b[11], mem_b[10], mem_b[9], mem_b[8]}  <= 32'h0000_3FFF;
            src_idx <= 0; snk_idx <= 0; wr_cnt <= 0; rd_cnt <= 0; lst_cnt <= 0;
        end else begin
            if (mem_req && !mem_err) begin
                if (mem_we) begin
                    for (int k = 0; k < 4; k++)
                        if (mem_be[k]) mem_b[ma + 14'(k)] <= mem_wdata[k*8 +: 8];
                    wr_cnt <= wr_cnt + 1;
                end else rd_cnt <= rd_cnt + 1;
            end
            if (lst_req) lst_cnt <= lst_cnt + 1;
            if (dev_rd_valid && dev_rd_ready) src_idx <= src_idx + 1;
            if (dev_wr_valid) begin
                snk_b[snk_idx] <= dev_wr_data;
                snk_idx <= snk_idx + 1;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wreg(logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [31:0] ctl(logic [1:0] c, bit dir, bit lst);
        return {28'd0, lst, dir, c};
    endfunction

    task automatic prep(int v, int lim);
        @(negedge clk);
        vec_id = v; src_lim = lim; fill_req = 1'b1;
        @(negedge clk);
        fill_req = 1'b0;
    endtask

    task automatic launch(bit dir, bit lst, int ofs, int cnt);
        wreg(2'd1, cnt);
        wreg(2'd2, ofs);
        wreg(2'd3, lst ? 32'h0 : 32'h1000);
        wreg(2'd0, ctl(2'd0, dir, lst));
        wreg(2'd0, ctl(2'd3, dir, lst));
    endtask

    task automatic wait_end();
        for (int i = 0; i < 20000 && status_o == 4'b0000; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    typedef struct packed {
        logic        dir;
        logic        lst;
        logic [11:0] ofs;
        logic [15:0] cnt;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b1, 1'b1, 12'h001, 16'd6},
        '{1'b1, 1'b1, 12'hFFD, 16'd9},
        '{1'b0, 1'b1, 12'hFFE, 16'd7},
        '{1'b0, 1'b1, 12'h000, 16'd4},
        '{1'b1, 1'b0, 12'hFFF, 16'd3},
        '{1'b0, 1'b0, 12'h002, 16'd5},
        '{1'b1, 1'b1, 12'h000, 16'd4100}
    };

    task automatic run_vec(vec_t t, int v);
        int bad, words, pages, ofs, cnt, a;
        ofs = int'(t.ofs); cnt = int'(t.cnt);
        prep(v, t.dir ? cnt : 0);
        launch(t.dir, t.lst, ofs, cnt);
        wait_end();
        chk("R6 done status", status_o, 4'b0001);
        bad = 0; words = 0;
        for (int i = 0; i < cnt; i++) begin
            a = pos2addr(t.lst, ofs + i);
            if (i == 0 || ((ofs + i) % 4) == 0) words++;
            if (t.dir) begin
                if (mem_b[a] !== src(i, v)) bad++;
            end else if (snk_b[i] !== mem_b[a]) bad++;
        end
        pages = t.lst ? ((ofs + cnt - 1) >> 12) + 1 : 0;
        chk(t.dir ? "R4 R3 packed bytes" : "R5 R3 emitted bytes", bad, 0);
        chk(t.lst ? "R2 table reads" : "R12 no table reads", lst_cnt, pages);
        if (t.dir) begin
            chk("R4 one write per word", wr_cnt, words);
            if (ofs > 0) begin
                a = pos2addr(t.lst, ofs - 1);
                chk("R4 lane before start untouched", mem_b[a], bg(a));
            end
            if (((ofs + cnt) & 32'hFFF) != 0) begin
                a = pos2addr(t.lst, ofs + cnt);
                chk("R4 lane after end untouched", mem_b[a], bg(a));
            end
        end else begin
            chk("R5 byte count", snk_idx, cnt);
            chk("R5 one read per word", rd_cnt, words);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", status_o, 0);
        chk("R1 command field", cmd_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 no requests", {lst_req, mem_req, dev_rd_ready, dev_wr_valid}, 0);

        for (int v = 0; v < 7; v++) run_vec(VECS[v], v);

        // R7: zero count, no access, DONE at once; R11 busy readback.
        prep(7, 0);
        launch(1'b1, 1'b1, 0, 0);
        chk("R7 zero count done", status_o, 4'b0001);
        chk("R7 no access", lst_cnt + wr_cnt + rd_cnt, 0);
        chk("R11 command readback", cmd_o, 3);
        chk("R11 busy when not idle", busy_o, 1);
        wreg(2'd0, ctl(2'd0, 1'b1, 1'b1));
        chk("R11 idle not busy", busy_o, 0);
        chk("R11 status sticky", status_o, 4'b0001);

        // R8: abort a long memory-to-device run.
        prep(8, 0);
        launch(1'b0, 1'b1, 0, 2000);
        repeat (20) @(negedge clk);
        wreg(2'd0, ctl(2'd2, 1'b0, 1'b1));
        chk("R8 requests removed", {lst_req, mem_req}, 0);
        chk("R8 abort status", status_o, 4'b0100);
        begin
            int seen;
            seen = rd_cnt + lst_cnt;
            repeat (10) @(negedge clk);
            chk("R8 no later access", rd_cnt + lst_cnt, seen);
        end

        // R9: flush of a two-byte partial word.
        prep(9, 2);
        launch(1'b1, 1'b1, 0, 10);
        repeat (20) @(negedge clk);
        wreg(2'd0, ctl(2'd1, 1'b1, 1'b1));
        repeat (3) @(negedge clk);
        chk("R9 flush status", status_o, 4'b1000);
        chk("R9 one flush write", wr_cnt, 1);
        chk("R9 flushed lanes", {mem_b[32'h2001], mem_b[32'h2000]}, {src(1, 9), src(0, 9)});
        chk("R9 unfilled lanes kept", {mem_b[32'h2003], mem_b[32'h2002]}, {bg(32'h2003), bg(32'h2002)});

        // R9: nothing held, so BLAST writes nothing more.
        prep(10, 4);
        launch(1'b1, 1'b1, 0, 10);
        repeat (20) @(negedge clk);
        wreg(2'd0, ctl(2'd1, 1'b1, 1'b1));
        repeat (3) @(negedge clk);
        chk("R9 empty flush status", status_o, 4'b1000);
        chk("R9 empty flush no write", wr_cnt, 1);

        // R10: bus error on the first read.
        prep(11, 0);
        err_inj = 1'b1;
        launch(1'b0, 1'b1, 0, 8);
        repeat (10) @(negedge clk);
        chk("R10 error status", status_o, 4'b0010);
        chk("R10 nothing delivered", snk_idx, 0);
        chk("R10 stopped", mem_req, 0);
        err_inj = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule